// File: doc/BRIEF.md
# Serial Gain-Word Programming Master

This block sits on the host side of a programmable-gain line amplifier. It turns a one-cycle request into the amplifier's three-wire gain-loading sequence and keeps the amplifier's transmit-enable level in a safe order. The request carries an 8-bit gain code and a flag saying whether transmission should be enabled once the code is in place. The block drops an active-low load window. It clocks the code out most significant bit first on eight serial clock pulses, then raises the load window to commit the word. After that it reports completion and, if asked, enables transmission.

All timing margins are counted in system-clock cycles. Each margin is a parameter that the integrator sets by rounding the amplifier's nanosecond minimum up to whole cycles. With the default 5 ns clock, the defaults are a serial clock high time of 4 cycles and a low time of 4 cycles, a load-window lead of 3 cycles and a commit hold of 1 cycle. A separate power-down request forces the transmit-enable level low at any time and leaves any serial transfer that is in flight untouched.

Top module: `gain_prog_master`

## Requirements
- R1: Each accepted request produces exactly WORD_W (8) rising edges on `serClk`. The value of `serData` at those edges, first edge first, equals `reqCode` from bit 7 down to bit 0.
- R2: `serClk` stays high for at least HIGH_CYC cycles per pulse and stays low for at least LOW_CYC cycles between consecutive pulses.
- R3: `loadEnN` falls at least SETUP_CYC cycles before the first rising edge of `serClk`, and `serClk` is never high while `loadEnN` is high.
- R4: `serData` changes only while `serClk` is low and never in the cycle in which `serClk` rises.
- R5: After the last falling edge of `serClk`, `loadEnN` stays low for at least HOLD_CYC cycles before it rises.
- R6: After reset `serClk` is 0, `loadEnN` is 1, `pwrUp` is 0, `busy` is 0 and `done` is 0. Between transfers `serClk` idles low and `loadEnN` idles high.
- R7: `busy` is 1 from the cycle after a request is accepted until `done`. `done` is a single-cycle pulse that comes exactly one cycle after `loadEnN` rises, and `busy` is 0 from then on.
- R8: `pwrUp` rises only in the cycle `done` pulses, and only when the request's `reqEnable` was 1. A transfer with `reqEnable` 0 leaves `pwrUp` at its previous level. Until the first commit, `pwrUp` stays 0.
- R9: A request presented while `busy` is 1 is ignored. The word in flight is not altered, and no extra transfer follows.
- R10: `pdReq` drives `pwrUp` to 0 on the next cycle in any state and does not disturb the serial sequence. When `pdReq` coincides with the commit of an enabling transfer, `pwrUp` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe, taken only when idle |
| reqCode | input | 8 | Gain code to be loaded |
| reqEnable | input | 1 | Enable transmission after the commit |
| pdReq | input | 1 | Force transmit-enable low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| serClk | output | 1 | Serial clock to amplifier, idles low |
| serData | output | 1 | Serial data to amplifier, MSB first |
| loadEnN | output | 1 | Active-low load window, rising edge commits the word |
| pwrUp | output | 1 | Transmit-enable level, high to transmit |

## Verification
The commit of an enabling transfer and an external power-down request can land on the same clock edge, and they pull `pwrUp` in opposite directions. The bench waits until it sees `loadEnN` rise and drives `pdReq` for exactly the next cycle, so the request meets the `done` edge. It then expects `done` to be 1 and `pwrUp` to be 0. A second case drops `pdReq` into the middle of the bit stream and requires the captured word, the pulse count and every timing margin to stay intact.

// File: rtl/gp_pkg.sv
package gp_pkg;

  // strobes from the sequencer to the serial datapath
  typedef struct packed {
    logic load;     // capture request, open load window
    logic rise;     // serial clock high
    logic fall;     // serial clock low
    logic shift;    // advance to next data bit
    logic relEn;    // close load window (commit)
    logic finish;   // completion pulse / enable update
  } gp_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_COMMIT
  } gp_state_t;

endpackage

// File: rtl/gp_ctrl.sv
module gp_ctrl
  import gp_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int SETUP_CYC = 3,
  parameter int HIGH_CYC  = 4,
  parameter int LOW_CYC   = 4,
  parameter int HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       busy,
  output gp_strobe_t strobes
);

  localparam int MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_B = (LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam int BW    = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  gp_state_t      state;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitCnt;
  int             phaseLen;
  logic           phaseEnd;
  logic           lastBit;

  always_comb begin
    case (state)
      ST_LEAD: phaseLen = SETUP_CYC;
      ST_HIGH: phaseLen = HIGH_CYC;
      ST_LOW:  phaseLen = LOW_CYC;
      ST_TAIL: phaseLen = HOLD_CYC;
      default: phaseLen = 1;
    endcase
  end

  assign phaseEnd = (int'(cnt) == phaseLen - 1);
  assign lastBit  = (int'(bitCnt) == WORD_W - 1);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobes        = '0;
    strobes.load   = (state == ST_IDLE) && reqValid;
    strobes.rise   = ((state == ST_LEAD) || (state == ST_LOW)) && phaseEnd;
    strobes.fall   = (state == ST_HIGH) && phaseEnd;
    strobes.shift  = (state == ST_HIGH) && phaseEnd && !lastBit;
    strobes.relEn  = (state == ST_TAIL) && phaseEnd;
    strobes.finish = (state == ST_COMMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt    <= '0;
          bitCnt <= '0;
          if (reqValid) state <= ST_LEAD;
        end
        ST_LEAD, ST_LOW: begin
          if (phaseEnd) begin
            cnt   <= '0;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            cnt    <= '0;
            bitCnt <= bitCnt + 1'b1;
            state  <= lastBit ? ST_TAIL : ST_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (phaseEnd) begin
            cnt   <= '0;
            state <= ST_COMMIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: once a transfer is under way, a new strobe does not restart it
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && state != ST_COMMIT) |=> busy);

endmodule

// File: rtl/gp_datapath.sv
module gp_datapath
  import gp_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gp_strobe_t        strobes,
  input  logic [WORD_W-1:0] reqCode,
  input  logic              reqEnable,
  input  logic              pdReq,
  output logic              serClk,
  output logic              serData,
  output logic              loadEnN,
  output logic              pwrUp,
  output logic              done
);

  logic [WORD_W-1:0] shiftReg;
  logic              enFlag;

  assign serData = shiftReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      enFlag   <= 1'b0;
    end else if (strobes.load) begin
      shiftReg <= reqCode;
      enFlag   <= reqEnable;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClk  <= 1'b0;
      loadEnN <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (strobes.rise)      serClk <= 1'b1;
      else if (strobes.fall) serClk <= 1'b0;
      if (strobes.load)       loadEnN <= 1'b0;
      else if (strobes.relEn) loadEnN <= 1'b1;
      done <= strobes.finish;
    end
  end

  // power-down has priority over the enable at commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pwrUp <= 1'b0;
    else if (pdReq)                   pwrUp <= 1'b0;
    else if (strobes.finish && enFlag) pwrUp <= 1'b1;
  end

  p_clk_in_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> !loadEnN);

  p_data_steady_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData));

  p_done_after_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (loadEnN && $past(loadEnN) && !$past(loadEnN, 2)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_enable_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrUp) |-> done);

  p_pd_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    pdReq |=> !pwrUp);

endmodule

// File: rtl/gain_prog_master.sv
module gain_prog_master
  import gp_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int SETUP_CYC = 3,
  parameter int HIGH_CYC  = 4,
  parameter int LOW_CYC   = 4,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WORD_W-1:0] reqCode,
  input  logic              reqEnable,
  input  logic              pdReq,
  output logic              busy,
  output logic              done,
  output logic              serClk,
  output logic              serData,
  output logic              loadEnN,
  output logic              pwrUp
);

  gp_strobe_t strobes;

  gp_ctrl #(
    .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busy(busy), .strobes(strobes)
  );

  gp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqCode(reqCode), .reqEnable(reqEnable), .pdReq(pdReq),
    .serClk(serClk), .serData(serData), .loadEnN(loadEnN),
    .pwrUp(pwrUp), .done(done)
  );

endmodule

// File: tb/tb_gain_prog_master.sv
module tb_gain_prog_master;

  localparam int SETUP_CYC = 3;
  localparam int HIGH_CYC  = 4;
  localparam int LOW_CYC   = 4;
  localparam int HOLD_CYC  = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqCode = '0;
  logic       reqEnable = 1'b0;
  logic       pdReq = 1'b0;
  logic       busy, done, serClk, serData, loadEnN, pwrUp;

  always #2.5 clk = ~clk;

  gain_prog_master #(
    .WORD_W(8), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .reqEnable(reqEnable), .pdReq(pdReq), .busy(busy), .done(done),
    .serClk(serClk), .serData(serData), .loadEnN(loadEnN), .pwrUp(pwrUp)
  );

  // {enable, code}
  localparam logic [8:0] VEC [6] = '{9'h080, 9'h101, 9'h0A5, 9'h1FF, 9'h000, 9'h15A};

  int nChecks = 0, nBad = 0;
  int monChecks = 0, monBad = 0;
  logic expPwr = 1'b0;

  // ---------------- monitor ----------------
  int cyc = 0, tEnFall = 0, tRise = 0, tFall = 0, tEnRise = -10;
  int pulses = 0;
  logic [7:0] word = '0;
  logic prevClk = 1'b0, prevEn = 1'b1, prevData = 1'b0, prevPwr = 1'b0;
  int doneCnt = 0;

  task automatic mon(input bit ok, input string req, input int act, input int exp);
    monChecks++;
    if (!ok) begin
      monBad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevEn && !loadEnN) begin
        tEnFall = cyc; pulses = 0; word = '0;
      end
      if (!prevClk && serClk) begin
        if (pulses == 0) mon(cyc - tEnFall >= SETUP_CYC, "R3 lead", cyc - tEnFall, SETUP_CYC);
        else             mon(cyc - tFall >= LOW_CYC, "R2 low", cyc - tFall, LOW_CYC);
        mon(!loadEnN, "R3 window", loadEnN, 0);
        word = {word[6:0], serData};
        pulses++;
        tRise = cyc;
      end
      if (prevClk && !serClk) begin
        mon(cyc - tRise >= HIGH_CYC, "R2 high", cyc - tRise, HIGH_CYC);
        tFall = cyc;
      end
      if (serData != prevData && serClk)
        mon(1'b0, "R4 data moved with clk high", serData, prevData);
      if (!prevEn && loadEnN) begin
        mon(cyc - tFall >= HOLD_CYC, "R5 hold", cyc - tFall, HOLD_CYC);
        mon(pulses == 8, "R1 pulse count", pulses, 8);
        tEnRise = cyc;
      end
      if (done) begin
        doneCnt++;
        mon(cyc - tEnRise == 1, "R7 done timing", cyc - tEnRise, 1);
      end
      if (pwrUp && !prevPwr) mon(done, "R8 enable without done", done, 1);
      prevClk = serClk; prevEn = loadEnN; prevData = serData; prevPwr = pwrUp;
    end
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input logic [7:0] code, input logic en);
    @(negedge clk);
    reqValid = 1'b1; reqCode = code; reqEnable = en;
    @(negedge clk);
    reqValid = 1'b0; reqCode = '0; reqEnable = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runXfer(input logic [7:0] code, input logic en);
    bit ok;
    int d0;
    d0 = doneCnt;
    request(code, en);
    chk(busy, "R7 busy after accept", busy, 1);
    waitDone(ok);
    chk(ok, "R7 done seen", ok, 1);
    chk(word == code, "R1 word", word, code);
    if (en) expPwr = 1'b1;
    chk(pwrUp == expPwr, "R8 pwrUp after commit", pwrUp, expPwr);
    chk(!busy, "R7 busy cleared", busy, 0);
    @(negedge clk);
    chk(!done && doneCnt == d0 + 1, "R7 single done", doneCnt - d0, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks + monChecks, nBad + monBad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(!serClk && loadEnN && !pwrUp && !busy && !done, "R6 reset state",
        {serClk, loadEnN, pwrUp, busy, done}, 5'b01000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!serClk && loadEnN, "R6 idle levels", {serClk, loadEnN}, 2'b01);

    // table of transfers
    for (int v = 0; v < 6; v++) begin
      runXfer(VEC[v][7:0], VEC[v][8]);
      repeat (2) @(negedge clk);
      chk(!serClk && loadEnN, "R6 idle between transfers", {serClk, loadEnN}, 2'b01);
    end

    // R9: request during busy ignored
    request(8'h96, 1'b1);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqCode = 8'h3C; reqEnable = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; reqCode = '0;
    waitDone(ok);
    chk(ok && word == 8'h96, "R9 word kept", word, 8'h96);
    repeat (4) @(negedge clk);
    chk(!busy && loadEnN && !serClk, "R9 no extra transfer", busy, 0);
    expPwr = 1'b1;

    // R10: power-down while idle, no serial activity
    chk(pwrUp, "R10 precondition pwrUp", pwrUp, 1);
    @(negedge clk); pdReq = 1'b1;
    @(negedge clk); pdReq = 1'b0;
    chk(!pwrUp, "R10 idle pd", pwrUp, 1'b0);
    repeat (5) @(negedge clk);
    chk(loadEnN && !serClk && !busy, "R10 idle pd no transfer", {loadEnN, serClk}, 2'b10);
    expPwr = 1'b0;

    // re-enable, then power-down mid transfer
    runXfer(8'h40, 1'b1);
    request(8'hC3, 1'b0);
    repeat (25) @(negedge clk);
    pdReq = 1'b1;
    @(negedge clk); pdReq = 1'b0;
    chk(!pwrUp, "R10 mid-transfer pd", pwrUp, 0);
    chk(busy, "R10 transfer continues", busy, 1);
    waitDone(ok);
    chk(ok && word == 8'hC3, "R10 word intact", word, 8'hC3);
    chk(!pwrUp, "R8 disabled transfer keeps low", pwrUp, 0);
    repeat (3) @(negedge clk);

    // R10: pd on the same edge as an enabling commit
    request(8'h08, 1'b1);
    for (int i = 0; i < 400; i++) begin
      if (loadEnN && prevEn) begin end
      @(negedge clk);
      if (loadEnN) break;
    end
    pdReq = 1'b1;
    @(negedge clk); pdReq = 1'b0;
    chk(done, "R7 done beside pd", done, 1);
    chk(!pwrUp, "R10 pd wins at commit", pwrUp, 0);
    chk(word == 8'h08, "R1 word at collision", word, 8'h08);
    repeat (3) @(negedge clk);
    chk(!pwrUp, "R10 stays low", pwrUp, 0);

    $display("test done: total=%0d bad=%0d", nChecks + monChecks, nBad + monBad);
    $finish;
  end

endmodule